// File: doc/BRIEF.md
# PCI initiator handshake rule checker

This block is a passive observer placed beside one bus master on a PCI segment. On every rising clock edge it samples the active-low control lines that the master and its target drive: frame, initiator ready, target ready, stop, and the grant for this master. It also samples a one-bit write indication that is meaningful in the address phase. From these samples it works out where the bus is in a transaction. That position is one of idle, address, data, last data, or the turnaround after the last data phase. It then judges each change of the control lines against the initiator-side signalling rules.

Each rule owns one bit position. A violation produces a one-clock pulse on that bit of `errPulse` and sets the matching bit of `errSticky`. The sticky bit holds until a synchronous clear. `errAny` reports whether any sticky bit is set. The block never drives the bus and does not look at addresses, data, or parity.

Bit map used throughout: 0 frame held after stop, 1 grant timeout, 2 frame without grant, 3 last phase without initiator ready, 4 initiator ready in address phase, 5 initiator ready outside a transaction, 6 phase instability or frame reassertion, 7 illegal back-to-back start, 8 lines not released after the last phase.

Top module: `pci_init_chk`

## Requirements
- R1: Inputs are active low and sampled on the rising edge. A rule broken by the sample taken at edge k raises its `errPulse` bit for exactly the clock following edge k+1. After a synchronous reset (`rstN` low), `errPulse`, `errSticky` and `errAny` are all zero.
- R2: Bit 1 pulses when grant is asserted with frame and initiator ready both deasserted for 17 (GNT_TIMEOUT+1) consecutive samples. The pulse comes on the 17th sample, and it does not repeat while that condition persists. Frame asserted on or before the 17th such sample raises nothing.
- R3: Bit 2 pulses on a sample where frame becomes asserted while grant was deasserted in the preceding sample.
- R4: Bit 0 pulses on a sample where frame and initiator ready are both asserted, and stop was asserted in an earlier sample of the same transaction.
- R5: Bit 3 pulses on a sample where frame has just been deasserted (asserted in the previous sample) and initiator ready is not asserted.
- R6: Bit 4 pulses on a sample where frame becomes asserted with initiator ready already asserted.
- R7: Bit 5 pulses when initiator ready is asserted with frame deasserted, outside a pending last data phase and outside the sample that follows a completed last phase.
- R8: Bit 6 pulses in two cases. The first is when, after a sample with initiator ready asserted and neither target ready nor stop asserted, initiator ready or frame changes level. The second is when frame is reasserted while the previous transaction is still open.
- R9: Bit 7 pulses when frame starts in the sample right after a sample with initiator ready asserted, unless the previous transaction was a write (`cmdWrite` high in its address phase). A write makes the back-to-back start legal.
- R10: Bit 8 pulses when initiator ready, target ready or stop is still asserted in the sample after a completed last data phase.
- R11: `errSticky` bits set together with their pulse and hold until `errClr` is sampled high. A clear empties all bits, except any bit whose violation is reported in the same clock. `errAny` is high exactly when some sticky bit is set.
- R12: Well-formed reads, writes, and back-to-back starts after a write raise no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | bus clock, rising edge used |
| rstN | input | 1 | synchronous reset, active low |
| errClr | input | 1 | synchronous clear of the sticky error bits |
| frameN | input | 1 | frame line, active low |
| irdyN | input | 1 | initiator ready, active low |
| trdyN | input | 1 | target ready, active low |
| stopN | input | 1 | target stop request, active low |
| gntN | input | 1 | grant to the watched master, active low |
| cmdWrite | input | 1 | high when the command in the address phase is a write |
| errPulse | output | 9 | one-clock violation pulse per rule |
| errSticky | output | 9 | held violation flags per rule |
| errAny | output | 1 | high while any sticky flag is set |

## Verification
The assertions assume that every input is a clean, synchronous level at the rising edge and carries no unknown values. They also assume that the write indication only matters in the sample where frame starts. The assertions reason about the sampled view, so they take as given that the one previous-sample register set reflects the true prior bus state since reset. The stimulus changes every input only on the falling edge and starts from an idle, ungranted bus after reset. Whenever it deliberately breaks one rule, it closes the transaction in an orderly way, so that each later vector is judged from a known phase.

// File: rtl/pci_init_chk_pkg.sv
package pci_init_chk_pkg;

  localparam int NUM_RULES = 9;

  // bit positions of the per-rule error vector
  localparam int RULE_STOP_HELD    = 0;
  localparam int RULE_GNT_TIMEOUT  = 1;
  localparam int RULE_NO_GRANT     = 2;
  localparam int RULE_LAST_NO_IRDY = 3;
  localparam int RULE_IRDY_ADDR    = 4;
  localparam int RULE_IRDY_IDLE    = 5;
  localparam int RULE_PHASE_CHANGE = 6;
  localparam int RULE_BACK2BACK    = 7;
  localparam int RULE_NO_RELEASE   = 8;

  // current sample, active-high
  typedef struct packed {
    logic frame;
    logic irdy;
    logic trdy;
    logic stop;
    logic gnt;
    logic wr;
  } busSampT;

  // previous sample, active-high
  typedef struct packed {
    logic frame;
    logic irdy;
    logic trdy;
    logic stop;
    logic gnt;
  } busPrevT;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_RULES-1:0] viol;
  } ruleStrobeT;

endpackage

// File: rtl/pci_init_chk_dp.sv
module pci_init_chk_dp
  import pci_init_chk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 errClr,
  input  logic                 frameN,
  input  logic                 irdyN,
  input  logic                 trdyN,
  input  logic                 stopN,
  input  logic                 gntN,
  input  logic                 cmdWrite,
  input  ruleStrobeT           stb,
  output busSampT              cur,
  output busPrevT              prv,
  output logic [NUM_RULES-1:0] errPulse,
  output logic [NUM_RULES-1:0] errSticky,
  output logic                 errAny
);

  // input capture and previous-sample ranks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur <= '0;
      prv <= '0;
    end else begin
      cur.frame <= ~frameN;
      cur.irdy  <= ~irdyN;
      cur.trdy  <= ~trdyN;
      cur.stop  <= ~stopN;
      cur.gnt   <= ~gntN;
      cur.wr    <= cmdWrite;
      prv.frame <= cur.frame;
      prv.irdy  <= cur.irdy;
      prv.trdy  <= cur.trdy;
      prv.stop  <= cur.stop;
      prv.gnt   <= cur.gnt;
    end
  end

  // one error cell per rule
  for (genvar r = 0; r < NUM_RULES; r++) begin : g_errCell
    always_ff @(posedge clk) begin
      if (!rstN) begin
        errPulse[r]  <= 1'b0;
        errSticky[r] <= 1'b0;
      end else begin
        errPulse[r]  <= stb.viol[r];
        errSticky[r] <= (errSticky[r] && !errClr) || stb.viol[r];
      end
    end
  end

  assign errAny = |errSticky;

  // R11: without a clear, no sticky bit ever drops
  a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    !errClr |=> ((errSticky & $past(errSticky)) == $past(errSticky)));

  // R11: a clear with no concurrent violation empties every bit
  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && (stb.viol == '0)) |=> (errSticky == '0));

endmodule

// File: rtl/pci_init_chk_ctrl.sv
module pci_init_chk_ctrl
  import pci_init_chk_pkg::*;
#(
  parameter int GNT_TIMEOUT = 16
)(
  input  logic       clk,
  input  logic       rstN,
  input  busSampT    cur,
  input  busPrevT    prv,
  output ruleStrobeT stb
);

  localparam int CNT_W = $clog2(GNT_TIMEOUT + 2);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(GNT_TIMEOUT);

  logic             inXfer;     // transaction open at start of sample
  logic             justDone;   // previous sample completed the last phase
  logic             xferWrite;  // current/last transaction is a write
  logic             stopLat;    // stop seen earlier in this transaction
  logic [CNT_W-1:0] gntCnt;     // granted idle samples so far

  logic frameStart, idleGnt, lastDone, prevOpen, frameOnlyIrdy;

  assign frameStart    = cur.frame && !prv.frame;
  assign idleGnt       = cur.gnt && !cur.frame && !cur.irdy;
  assign lastDone      = inXfer && !cur.frame && cur.irdy && (cur.trdy || cur.stop);
  assign prevOpen      = prv.irdy && !(prv.trdy || prv.stop);
  assign frameOnlyIrdy = cur.irdy && !cur.frame;

  always_comb begin
    stb.viol = '0;
    stb.viol[RULE_STOP_HELD]    = cur.frame && cur.irdy && stopLat;
    stb.viol[RULE_GNT_TIMEOUT]  = idleGnt && (gntCnt == CNT_LIMIT);
    stb.viol[RULE_NO_GRANT]     = frameStart && !prv.gnt;
    stb.viol[RULE_LAST_NO_IRDY] = prv.frame && !cur.frame && !cur.irdy;
    stb.viol[RULE_IRDY_ADDR]    = frameStart && cur.irdy;
    stb.viol[RULE_IRDY_IDLE]    = frameOnlyIrdy && !inXfer && !justDone;
    stb.viol[RULE_PHASE_CHANGE] = (prevOpen && ((cur.irdy != prv.irdy) || (cur.frame != prv.frame)))
                                  || (frameStart && inXfer);
    stb.viol[RULE_BACK2BACK]    = frameStart && prv.irdy && !xferWrite;
    stb.viol[RULE_NO_RELEASE]   = justDone && (cur.irdy || cur.trdy || cur.stop);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inXfer    <= 1'b0;
      justDone  <= 1'b0;
      xferWrite <= 1'b0;
      stopLat   <= 1'b0;
      gntCnt    <= '0;
    end else begin
      inXfer   <= cur.frame || (inXfer && cur.irdy && !(cur.trdy || cur.stop));
      justDone <= lastDone;
      if (frameStart) begin
        xferWrite <= cur.wr;
      end
      if (frameStart || !(cur.frame || cur.irdy)) begin
        stopLat <= 1'b0;
      end else if (cur.stop) begin
        stopLat <= 1'b1;
      end
      if (!idleGnt) begin
        gntCnt <= '0;
      end else if (gntCnt <= CNT_LIMIT) begin
        gntCnt <= gntCnt + 1'b1;
      end
    end
  end

  // R2: the timeout reports once per grant window, never two clocks running
  a_r2_timeout_once: assert property (@(posedge clk) disable iff (!rstN)
    stb.viol[RULE_GNT_TIMEOUT] |=> !stb.viol[RULE_GNT_TIMEOUT]);

  // R6: an address phase flagged for early ready still opens a transaction
  a_r6_start_tracked: assert property (@(posedge clk) disable iff (!rstN)
    stb.viol[RULE_IRDY_ADDR] |=> inXfer);

  // R7: a fully idle sample closes any open transaction
  a_r7_idle_closes: assert property (@(posedge clk) disable iff (!rstN)
    (!cur.frame && !cur.irdy) |=> !inXfer);

  // R10: the release check only follows a completed last phase
  a_r10_release_after_done: assert property (@(posedge clk) disable iff (!rstN)
    stb.viol[RULE_NO_RELEASE] |-> $past(!cur.frame && cur.irdy && (cur.trdy || cur.stop)));

endmodule

// File: rtl/pci_init_chk.sv
module pci_init_chk
  import pci_init_chk_pkg::*;
#(
  parameter int GNT_TIMEOUT = 16
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 errClr,
  input  logic                 frameN,
  input  logic                 irdyN,
  input  logic                 trdyN,
  input  logic                 stopN,
  input  logic                 gntN,
  input  logic                 cmdWrite,
  output logic [NUM_RULES-1:0] errPulse,
  output logic [NUM_RULES-1:0] errSticky,
  output logic                 errAny
);

  busSampT    cur;
  busPrevT    prv;
  ruleStrobeT stb;

  pci_init_chk_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .errClr    (errClr),
    .frameN    (frameN),
    .irdyN     (irdyN),
    .trdyN     (trdyN),
    .stopN     (stopN),
    .gntN      (gntN),
    .cmdWrite  (cmdWrite),
    .stb       (stb),
    .cur       (cur),
    .prv       (prv),
    .errPulse  (errPulse),
    .errSticky (errSticky),
    .errAny    (errAny)
  );

  pci_init_chk_ctrl #(
    .GNT_TIMEOUT (GNT_TIMEOUT)
  ) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .cur  (cur),
    .prv  (prv),
    .stb  (stb)
  );

endmodule

// File: tb/pci_init_chk_tb_top.sv
`timescale 1ns/1ps
module pci_init_chk_tb_top;

  localparam real CLK_PERIOD = 5.0;
  localparam int  NV = 48;

  logic       clk = 1'b0;
  logic       rstN, errClr;
  logic       frameN, irdyN, trdyN, stopN, gntN, cmdWrite;
  logic [8:0] errPulse, errSticky;
  logic       errAny;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_init_chk dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .errClr    (errClr),
    .frameN    (frameN),
    .irdyN     (irdyN),
    .trdyN     (trdyN),
    .stopN     (stopN),
    .gntN      (gntN),
    .cmdWrite  (cmdWrite),
    .errPulse  (errPulse),
    .errSticky (errSticky),
    .errAny    (errAny)
  );

  // {requirement, frame irdy trdy stop gnt write (asserted = 1), expected pulse}
  localparam logic [18:0] VEC [NV] = '{
    {4'd12, 6'b000010, 9'h000},  // R12 granted idle
    {4'd12, 6'b100010, 9'h000},  // R12 read address
    {4'd12, 6'b110010, 9'h000},  // R12 wait
    {4'd12, 6'b111010, 9'h000},  // R12 data
    {4'd12, 6'b011010, 9'h000},  // R12 last data
    {4'd12, 6'b000010, 9'h000},  // R12 turnaround
    {4'd12, 6'b100011, 9'h000},  // R12 write address
    {4'd12, 6'b011010, 9'h000},  // R12 single last data
    {4'd9,  6'b100010, 9'h000},  // R9 back-to-back after write is legal
    {4'd9,  6'b011010, 9'h000},
    {4'd9,  6'b100010, 9'h080},  // R9 back-to-back after read
    {4'd9,  6'b011010, 9'h000},
    {4'd1,  6'b000000, 9'h000},  // R1 pulse lasts one clock
    {4'd3,  6'b100000, 9'h004},  // R3 frame without prior grant
    {4'd3,  6'b011000, 9'h000},
    {4'd3,  6'b000000, 9'h000},
    {4'd6,  6'b000010, 9'h000},
    {4'd6,  6'b110010, 9'h010},  // R6 ready in address phase
    {4'd6,  6'b111010, 9'h000},
    {4'd6,  6'b011010, 9'h000},
    {4'd5,  6'b000010, 9'h000},
    {4'd5,  6'b100010, 9'h000},
    {4'd5,  6'b000010, 9'h008},  // R5 frame drops without ready
    {4'd5,  6'b000010, 9'h000},
    {4'd7,  6'b011010, 9'h020},  // R7 ready with no transaction
    {4'd7,  6'b000000, 9'h000},
    {4'd8,  6'b000010, 9'h000},
    {4'd8,  6'b100010, 9'h000},
    {4'd8,  6'b110010, 9'h000},
    {4'd8,  6'b100010, 9'h040},  // R8 ready withdrawn mid phase
    {4'd8,  6'b111010, 9'h000},
    {4'd8,  6'b011010, 9'h000},
    {4'd8,  6'b000010, 9'h000},
    {4'd8,  6'b100010, 9'h000},
    {4'd8,  6'b010010, 9'h000},
    {4'd8,  6'b110010, 9'h0D0},  // R8 frame reasserted in open transaction
    {4'd8,  6'b111010, 9'h000},
    {4'd8,  6'b011010, 9'h000},
    {4'd4,  6'b000010, 9'h000},
    {4'd4,  6'b100010, 9'h000},
    {4'd4,  6'b110110, 9'h000},  // stop on first data phase
    {4'd4,  6'b110110, 9'h001},  // R4 frame still held after stop
    {4'd4,  6'b010110, 9'h000},
    {4'd4,  6'b000010, 9'h000},
    {4'd10, 6'b100010, 9'h000},
    {4'd10, 6'b011010, 9'h000},
    {4'd10, 6'b001010, 9'h100},  // R10 target ready not released
    {4'd10, 6'b000000, 9'h000}
  };

  task automatic drive(input logic [5:0] v);
    frameN   = ~v[5];
    irdyN    = ~v[4];
    trdyN    = ~v[3];
    stopN    = ~v[2];
    gntN     = ~v[1];
    cmdWrite =  v[0];
  endtask

  task automatic checkVal(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN   = 1'b0;
    errClr = 1'b0;
    drive(6'b000000);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkVal("R1 reset pulse", errPulse, 9'h000);
    checkVal("R1 reset sticky", errSticky, 9'h000);
    checkVal("R1 reset any", {8'h00, errAny}, 9'h000);

    for (int idx = 0; idx < NV + 2; idx++) begin
      @(negedge clk);
      if (idx >= 2) begin
        checkVal($sformatf("R%0d vector %0d", VEC[idx-2][18:15], idx - 2),
                 errPulse, VEC[idx-2][8:0]);
      end
      if (idx < NV) drive(VEC[idx][14:9]);
      else          drive(6'b000000);
    end

    // R11 sticky collects every rule hit so far
    @(negedge clk);
    checkVal("R11 sticky after table", errSticky, 9'h1FD);
    checkVal("R11 any after table", {8'h00, errAny}, 9'h001);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
    checkVal("R11 sticky after clear", errSticky, 9'h000);
    checkVal("R11 any after clear", {8'h00, errAny}, 9'h000);

    // R2 grant timeout: 17th granted idle sample reports, once
    drive(6'b000010);
    for (int j = 1; j <= 19; j++) begin
      @(negedge clk);
      checkVal($sformatf("R2 timeout clock %0d", j), errPulse, (j == 18) ? 9'h002 : 9'h000);
    end
    drive(6'b000000);
    @(negedge clk);
    @(negedge clk);
    checkVal("R2 timeout sticky", errSticky, 9'h002);

    // R2 frame on the 17th granted sample is on time
    drive(6'b000010);
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      checkVal($sformatf("R2 on-time clock %0d", j), errPulse, 9'h000);
      if (j < 16)       drive(6'b000010);
      else if (j == 16) drive(6'b100010);
      else if (j == 17) drive(6'b011010);
      else              drive(6'b000000);
    end

    // R11 a clear in the clock a violation reports keeps that bit
    drive(6'b011000);
    @(negedge clk);
    drive(6'b000000);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
    checkVal("R11 clear with new violation sticky", errSticky, 9'h020);
    checkVal("R7 pulse during clear", errPulse, 9'h020);
    @(negedge clk);
    checkVal("R1 pulse gone next clock", errPulse, 9'h000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule